// File: doc/BRIEF.md
# Windowed Fast Link-Down Monitor

This block decides when a 100 Mb/s receive link should be declared lost. Every clock it samples four single-cycle event flags produced elsewhere in the receiver: a receive error seen on the MAC-side data path, a violation of the three-level line code, a dip of the signal-quality metric below its threshold, and a loss-of-energy indication. Three of these are counted within a repeating observation window. Each has its own trip count, and every count restarts when a window ends. Energy loss needs no counting and trips as soon as it is seen. A 4-bit enable selects any subset of the four criteria.

A mode pin selects one of two window lengths. The short window is 250 cycles, which is 10 µs at a 25 MHz clock. The long window defaults to 25,000 cycles, which keeps link drops under about 1 ms. When any enabled criterion trips, the block emits a one-cycle drop pulse and sets a sticky cause bit for each criterion that tripped. It then stops watching until a rearm input restarts it with a fresh window and empty counters. The link state machine consumes the drop pulse, and the cause bits stay set until the clear input is asserted.

No data stream passes through this block, so it has no valid/ready handshake. All pins are plain level-sampled control and status signals.

Top module: `link_drop_monitor`

## Requirements
- R1: After reset `drop_pulse` is 0, `cause` is 0000 and `armed` is 1. The first window starts in the cycle after reset is released.
- R2: With `fast_mode`=1 a window lasts FAST_WIN (250) cycles, and with `fast_mode`=0 it lasts SLOW_WIN cycles. An event in the last cycle of a window still counts toward a trip. All event counts return to zero after that last cycle, so events split across two windows never add up.
- R3: Criterion 0 (`ev_rxerr`, enable bit 0) trips in the cycle that carries the 32nd counted event of a window. `drop_pulse` is then 1 in the following cycle, with `cause[0]` set.
- R4: Criterion 1 (`ev_mlt3`, enable bit 1) trips on the 20th counted event of a window and sets `cause[1]`.
- R5: Criterion 2 (`ev_lowsq`, enable bit 2) trips on the 20th counted event of a window and sets `cause[2]`.
- R6: Criterion 3 (`ev_enloss`, enable bit 3) trips on a single event. The pulse and `cause[3]` follow in the next cycle.
- R7: An event whose enable bit is 0 is not counted and never causes a drop.
- R8: `drop_pulse` is one cycle wide. After a drop, `armed` is 0 and every event is ignored until `rearm` is seen. The cycle after `rearm` begins a new window, with all counts at zero. `rearm` has no effect while armed.
- R9: `cause` bits accumulate across drops and stay set until `cause_clr`. A trip in the same cycle as `cause_clr` leaves only the new bits set.
- R10: Criteria that trip in the same cycle produce a single pulse, with all of their cause bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects the short window, 0 selects the long window |
| crit_en | input | 4 | Criterion enables; bit 0 rx error, 1 line-code violation, 2 low quality, 3 energy loss |
| ev_rxerr | input | 1 | Receive-error event this cycle |
| ev_mlt3 | input | 1 | Line-code violation event this cycle |
| ev_lowsq | input | 1 | Low signal-quality event this cycle |
| ev_enloss | input | 1 | Energy-loss indication this cycle |
| rearm | input | 1 | Resume monitoring after a drop |
| cause_clr | input | 1 | Clear the sticky cause bits |
| drop_pulse | output | 1 | One-cycle link-drop request |
| cause | output | 4 | Sticky per-criterion cause bits, same bit order as `crit_en` |
| armed | output | 1 | 1 while monitoring is active |

## Verification
The assertions assume that every input is a synchronous level sampled once per clock. Any mix of events, enables, `rearm` and `cause_clr` is legal in any cycle, and `fast_mode` may change in the middle of a window. The window logic treats any position at or past the new limit as the window's end, so a mode change cuts a long window short instead of letting it run over. The random stimulus flips the mode and the enables at arbitrary cycles and pulses `rearm` and `cause_clr` at random. A bench model follows the same cycle rules and is compared cycle by cycle. Directed runs align a window after a rearm and place events on both sides of a boundary.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

  localparam int NCRIT = 4;
  localparam int NCOUNTED = 3;

  // Bit positions shared by crit_en and cause
  localparam int CR_RXERR  = 0;
  localparam int CR_MLT3   = 1;
  localparam int CR_LOWSQ  = 2;
  localparam int CR_ENLOSS = 3;

  typedef logic [NCRIT-1:0] crit_vec_t;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lnkmon_window.sv
module lnkmon_window #(
  parameter int FAST_WIN = 250,
  parameter int SLOW_WIN = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast_mode,
  output logic win_end
);
  import lnkmon_pkg::*;

  localparam int WMAX = max_int(FAST_WIN, SLOW_WIN);
  localparam int W    = $clog2(WMAX + 1);
  localparam logic [W-1:0] FAST_LAST = W'(FAST_WIN - 1);
  localparam logic [W-1:0] SLOW_LAST = W'(SLOW_WIN - 1);
  localparam logic [W-1:0] TOP_LAST  = W'(WMAX - 1);

  logic [W-1:0] pos_q;
  logic [W-1:0] last;

  assign last    = fast_mode ? FAST_LAST : SLOW_LAST;
  assign win_end = run && (pos_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (!run || win_end) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= TOP_LAST);  // R2
  AST_HALT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0));  // R8

endmodule

// File: rtl/lnkmon_evcount.sv
module lnkmon_evcount #(
  parameter int THR = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  input  logic ev,
  input  logic win_end,
  output logic hit
);
  localparam int CW = $clog2(THR + 1);
  localparam logic [CW-1:0] THR_V  = CW'(THR);
  localparam logic [CW-1:0] THR_M1 = CW'(THR - 1);

  logic [CW-1:0] cnt_q;
  logic          counted;

  assign counted = run && en && ev;
  assign hit     = counted && (cnt_q == THR_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || win_end) begin
      cnt_q <= '0;
    end else if (counted && (cnt_q != THR_V)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= THR_V);  // R3
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || win_end) |=> (cnt_q == '0));  // R2
  AST_MASKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_end && !en) |=> $stable(cnt_q));  // R7

endmodule

// File: rtl/lnkmon_arbiter.sv
module lnkmon_arbiter
  import lnkmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  crit_vec_t trip,
  input  logic      rearm,
  input  logic      cause_clr,
  output logic      armed,
  output logic      drop_pulse,
  output crit_vec_t cause
);

  logic      armed_q;
  logic      drop_q;
  crit_vec_t cause_q;
  logic      any_trip;

  assign any_trip = |trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      drop_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      drop_q  <= any_trip;
      cause_q <= (cause_clr ? '0 : cause_q) | trip;
      if (any_trip) begin
        armed_q <= 1'b0;
      end else if (!armed_q && rearm) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign armed      = armed_q;
  assign drop_pulse = drop_q;
  assign cause      = cause_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |=> !drop_q);  // R8
  AST_CAUSE_WITH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> (cause_q != '0));  // R9
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));  // R9
  AST_DISARM_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> !armed_q);  // R8

endmodule

// File: rtl/link_drop_monitor.sv
module link_drop_monitor #(
  parameter int FAST_WIN  = 250,
  parameter int SLOW_WIN  = 25000,
  parameter int RXERR_THR = 32,
  parameter int MLT3_THR  = 20,
  parameter int LOWSQ_THR = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic [3:0] crit_en,
  input  logic       ev_rxerr,
  input  logic       ev_mlt3,
  input  logic       ev_lowsq,
  input  logic       ev_enloss,
  input  logic       rearm,
  input  logic       cause_clr,
  output logic       drop_pulse,
  output logic [3:0] cause,
  output logic       armed
);
  import lnkmon_pkg::*;

  crit_vec_t ev_vec;
  crit_vec_t trip;
  crit_vec_t cause_w;
  logic      win_end;
  logic      armed_w;
  logic      drop_w;

  assign ev_vec[CR_RXERR]  = ev_rxerr;
  assign ev_vec[CR_MLT3]   = ev_mlt3;
  assign ev_vec[CR_LOWSQ]  = ev_lowsq;
  assign ev_vec[CR_ENLOSS] = ev_enloss;

  lnkmon_window #(
    .FAST_WIN (FAST_WIN),
    .SLOW_WIN (SLOW_WIN)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (armed_w),
    .fast_mode (fast_mode),
    .win_end   (win_end)
  );

  for (genvar g = 0; g < NCOUNTED; g++) begin : g_cnt
    localparam int THR = (g == CR_RXERR) ? RXERR_THR :
                         (g == CR_MLT3)  ? MLT3_THR  : LOWSQ_THR;
    lnkmon_evcount #(
      .THR (THR)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (armed_w),
      .en      (crit_en[g]),
      .ev      (ev_vec[g]),
      .win_end (win_end),
      .hit     (trip[g])
    );
  end

  assign trip[CR_ENLOSS] = armed_w && crit_en[CR_ENLOSS] && ev_vec[CR_ENLOSS];

  lnkmon_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip       (trip),
    .rearm      (rearm),
    .cause_clr  (cause_clr),
    .armed      (armed_w),
    .drop_pulse (drop_w),
    .cause      (cause_w)
  );

  assign drop_pulse = drop_w;
  assign cause      = cause_w;
  assign armed      = armed_w;

  AST_ENLOSS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && crit_en[CR_ENLOSS] && ev_enloss) |=> (drop_pulse && cause[CR_ENLOSS]));  // R6
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_en == 4'b0000) |=> !drop_pulse);  // R7
  AST_IDLE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !drop_pulse);  // R8

endmodule

// File: tb/sim_link_drop_monitor.sv
module sim_link_drop_monitor;
  localparam int FAST = 250;
  localparam int SLOW = 2000;
  localparam int TRX  = 32;
  localparam int TML  = 20;
  localparam int TLS  = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       fast_mode;
  logic [3:0] crit_en;
  logic       ev_rxerr, ev_mlt3, ev_lowsq, ev_enloss, rearm, cause_clr;
  wire        drop_pulse;
  wire  [3:0] cause;
  wire        armed;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  link_drop_monitor #(
    .FAST_WIN (FAST), .SLOW_WIN (SLOW),
    .RXERR_THR (TRX), .MLT3_THR (TML), .LOWSQ_THR (TLS)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .fast_mode (fast_mode), .crit_en (crit_en),
    .ev_rxerr (ev_rxerr), .ev_mlt3 (ev_mlt3), .ev_lowsq (ev_lowsq),
    .ev_enloss (ev_enloss), .rearm (rearm), .cause_clr (cause_clr),
    .drop_pulse (drop_pulse), .cause (cause), .armed (armed)
  );

  function automatic int thr_of(int i);
    return (i == 0) ? TRX : ((i == 1) ? TML : TLS);
  endfunction

  // Reference model built from the requirements
  logic       m_armed, m_drop;
  logic [3:0] m_cause;
  int         m_w;
  int         m_cnt [3];

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] trip;
    logic [3:0] ev;
    int last;
    if (!rst_n) begin
      m_armed = 1'b1; m_drop = 1'b0; m_cause = 4'b0; m_w = 0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    end else begin
      ev   = {ev_enloss, ev_lowsq, ev_mlt3, ev_rxerr};
      last = fast_mode ? FAST - 1 : SLOW - 1;
      for (int i = 0; i < 3; i++)
        trip[i] = m_armed && crit_en[i] && ev[i] && (m_cnt[i] == thr_of(i) - 1);
      trip[3] = m_armed && crit_en[3] && ev[3];
      for (int i = 0; i < 3; i++) begin
        if (!m_armed || m_w >= last) m_cnt[i] = 0;
        else if (crit_en[i] && ev[i] && m_cnt[i] < thr_of(i)) m_cnt[i] = m_cnt[i] + 1;
      end
      if (!m_armed || m_w >= last) m_w = 0; else m_w = m_w + 1;
      m_cause = (cause_clr ? 4'b0 : m_cause) | trip;
      m_drop  = |trip;
      if (|trip) m_armed = 1'b0;
      else if (!m_armed && rearm) m_armed = 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("R3 drop_pulse vs model", drop_pulse, m_drop);
    chk("R9 cause vs model", cause, m_cause);
    chk("R8 armed vs model", armed, m_armed);
  endtask

  task automatic quiet();
    ev_rxerr = 0; ev_mlt3 = 0; ev_lowsq = 0; ev_enloss = 0;
    rearm = 0; cause_clr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // Leaves the block armed, cause clear, window position 0 in the next cycle
  task automatic realign(bit f);
    quiet();
    fast_mode = f;
    crit_en = 4'b1000; ev_enloss = 1; cyc();
    ev_enloss = 0; cyc();
    rearm = 1; cause_clr = 1; cyc();
    rearm = 0; cause_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; fast_mode = 1; crit_en = 4'b1111; quiet();
    repeat (3) @(negedge clk);
    chk("R1 reset drop", drop_pulse, 0);
    chk("R1 reset cause", cause, 0);
    chk("R1 reset armed", armed, 1);
    rst_n = 1;
    idle(5);
    chk("R1 idle after reset", armed, 1);

    // R3: 32nd receive error trips
    realign(1); crit_en = 4'b0001; ev_rxerr = 1;
    idle(31);
    chk("R3 no drop at 31 events", drop_pulse, 0);
    cyc();
    chk("R3 drop at 32 events", drop_pulse, 1);
    chk("R3 cause bit0", cause, 4'b0001);
    ev_rxerr = 0; cyc();
    chk("R8 pulse one cycle", drop_pulse, 0);
    chk("R8 disarmed after drop", armed, 0);

    // R4
    realign(1); crit_en = 4'b0010; ev_mlt3 = 1;
    idle(19);
    chk("R4 no drop at 19", drop_pulse, 0);
    cyc();
    chk("R4 drop at 20", drop_pulse, 1);
    chk("R4 cause bit1", cause, 4'b0010);
    ev_mlt3 = 0;

    // R5
    realign(1); crit_en = 4'b0100; ev_lowsq = 1;
    idle(19);
    chk("R5 no drop at 19", drop_pulse, 0);
    cyc();
    chk("R5 drop at 20", drop_pulse, 1);
    chk("R5 cause bit2", cause, 4'b0100);
    ev_lowsq = 0;

    // R2: split across a short window boundary
    realign(1); crit_en = 4'b0010;
    idle(FAST - 19);
    ev_mlt3 = 1; idle(38);
    chk("R2 split events no drop", armed, 1);
    chk("R2 split events no cause", cause, 0);
    cyc();
    chk("R2 20th in second window", drop_pulse, 1);
    ev_mlt3 = 0;

    // R2: long window is longer than the short one
    realign(0); crit_en = 4'b0010;
    ev_mlt3 = 1; idle(19); ev_mlt3 = 0;
    idle(400 - 19);
    chk("R2 slow still armed", armed, 1);
    ev_mlt3 = 1; cyc(); ev_mlt3 = 0;
    chk("R2 slow window drop", drop_pulse, 1);

    // R2: split across a long window boundary
    realign(0); crit_en = 4'b0010;
    idle(SLOW - 10);
    ev_mlt3 = 1; idle(20); ev_mlt3 = 0;
    chk("R2 slow split no drop", armed, 1);
    idle(2);

    // R6
    realign(1); crit_en = 4'b1000; ev_enloss = 1; cyc(); ev_enloss = 0;
    chk("R6 energy loss drop", drop_pulse, 1);
    chk("R6 cause bit3", cause, 4'b1000);

    // R7
    realign(1); crit_en = 4'b0000;
    ev_rxerr = 1; ev_mlt3 = 1; ev_lowsq = 1; ev_enloss = 1; idle(40);
    chk("R7 none enabled armed", armed, 1);
    chk("R7 none enabled cause", cause, 0);
    crit_en = 4'b0001; ev_rxerr = 0; idle(40);
    chk("R7 masked others armed", armed, 1);
    quiet();

    // R8: ignored while disarmed, rearm restarts counts
    crit_en = 4'b1000; ev_enloss = 1; cyc();
    chk("R8 drop", drop_pulse, 1);
    crit_en = 4'b1111; ev_rxerr = 1; ev_mlt3 = 1; ev_lowsq = 1; idle(10);
    chk("R8 no drop while disarmed", drop_pulse, 0);
    chk("R8 cause unchanged while disarmed", cause, 4'b1000);
    quiet(); rearm = 1; cyc(); rearm = 0;
    chk("R8 rearmed", armed, 1);
    crit_en = 4'b0010; ev_mlt3 = 1; idle(19);
    chk("R8 counts restarted", drop_pulse, 0);
    cyc(); ev_mlt3 = 0;
    chk("R8 drop after rearm", drop_pulse, 1);

    // R9
    chk("R9 accumulate", cause, 4'b1010);
    idle(50);
    chk("R9 sticky", cause, 4'b1010);
    rearm = 1; cyc(); rearm = 0;
    crit_en = 4'b1000; ev_enloss = 1; cause_clr = 1; cyc();
    ev_enloss = 0; cause_clr = 0;
    chk("R9 trip wins over clear", cause, 4'b1000);
    cause_clr = 1; cyc(); cause_clr = 0;
    chk("R9 clear", cause, 4'b0000);

    // R10
    realign(1); crit_en = 4'b1111;
    ev_mlt3 = 1; ev_lowsq = 1; idle(19);
    ev_enloss = 1; cyc(); quiet();
    chk("R10 single pulse", drop_pulse, 1);
    chk("R10 all causes", cause, 4'b1110);
    cyc();
    chk("R10 pulse ends", drop_pulse, 0);

    // Random phase
    quiet(); fast_mode = 1; crit_en = 4'b1111;
    for (int n = 0; n < 30000; n++) begin
      if ($urandom_range(1999) == 0) fast_mode = ~fast_mode;
      if ($urandom_range(299) == 0) crit_en = 4'($urandom_range(15));
      ev_rxerr  = ($urandom_range(5) == 0);
      ev_mlt3   = ($urandom_range(9) == 0);
      ev_lowsq  = ($urandom_range(9) == 0);
      ev_enloss = ($urandom_range(399) == 0);
      rearm     = ($urandom_range(39) == 0);
      cause_clr = ($urandom_range(49) == 0);
      cyc();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule